// File: doc/BRIEF.md
# Up-counting interval timer with posted register writes

This block is a general-purpose up-counter that raises an interrupt when it wraps. Its registers sit on a simple synchronous bus clocked by `bclk`. The counter runs on a separate functional clock `tclk`, and the two clocks are not related. Software sets up a single event by writing the counter with the all-ones value minus N and then setting the run bit. Periodic events use auto-reload: on every wrap the counter restarts from the load register.

Each write to a register in the timer domain is carried across as a toggle request with a toggle acknowledge, through two-flop synchronisers in each direction. The write data is held stable in the bus domain until the acknowledge returns. In posted mode the bus accepts the write at once, and a per-register pending bit shows that the write is still in flight. A second write to a register whose bit is still set is held on the bus with `bus_stall` until the first one lands. In non-posted mode every timer-domain write stalls the bus until it has landed. Counter and control values are read back through a shadow copy that the timer domain refreshes without pause, so a read always returns a coherent value.

Top module: `ptimer`

## Requirements
- R1: After reset every readable register reads 0, `irq` is 0 and `bus_stall` is 0 while no write is presented.
- R2: Register map (word addresses): 0 control (bit0 run, bit1 auto-reload), 1 load, 2 counter, 3 interrupt status, 4 interrupt enable, 5 write-pending, 6 config. A running counter without auto-reload that wraps past the all-ones value goes to 0, clears the run bit (control reads bit0 = 0) and then stays at 0.
- R3: With auto-reload set, the counter restarts from the load value on every wrap. The interval between overflow events is (all-ones − load + 1) timer cycles.
- R4: Every wrap sets status bit0 (address 3). Writing 1 to that bit clears it. Writing 0 leaves it unchanged.
- R5: `irq` equals status bit0 ANDed with enable bit0 (address 4). With the enable at 0, a set flag does not drive `irq`.
- R6: The counter read (address 2) gives a coherent value that increases at the timer clock rate while the counter runs.
- R7: Config bit0 (address 6) = 1 selects posted mode. In that mode a write to control, load or counter is accepted without a stall and sets its pending bit (address 5: bit0 control, bit1 load, bit2 counter). The bit clears once the write has taken effect in the timer domain.
- R8: A write to a timer-domain register whose pending bit is set is held with `bus_stall` until that bit clears, and is then accepted. The data of the write in flight stays unchanged until it lands.
- R9: Config bit0 = 0 (the reset value) selects non-posted mode. A write to control, load or counter stalls the bus until it has taken effect, and when the stall drops the pending bits read 0.
- R10: The shortest interval, a load of all-ones − 2 (three timer cycles), still produces one overflow event every three timer cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| brst_n | input | 1 | Bus-domain reset, active low |
| bus_we | input | 1 | Write strobe, held while `bus_stall` is high |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | CW | Write data |
| bus_rdata | output | CW | Read data for `bus_addr` |
| bus_stall | output | 1 | Write not yet accepted, hold the bus |
| irq | output | 1 | Overflow interrupt |
| tclk | input | 1 | Timer functional clock |
| trst_n | input | 1 | Timer-domain reset, active low |

## Verification
The assertions assume a bus master that keeps `bus_we`, `bus_addr` and `bus_wdata` steady for as long as `bus_stall` is high. They also assume that the two resets are applied together. The bench drives every write through one task that changes the bus only at the falling edge of `bclk` and holds it until a rising edge with no stall. It sweeps the auto-reload interval from three to ten timer cycles. It times the interval between `irq` rises against a tolerance of one bus cycle, because synchronising the overflow into the bus domain adds that much jitter.

// File: rtl/ptimer.sv
module ptimer #(
  parameter int CW = 32
) (
  input  logic          bclk,
  input  logic          brst_n,
  input  logic          bus_we,
  input  logic [2:0]    bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic          bus_stall,
  output logic          irq,
  input  logic          tclk,
  input  logic          trst_n
);
  localparam logic [CW-1:0] MAXV = '1;
  localparam logic [2:0] A_CTL = 3'd0, A_LD = 3'd1, A_CNT = 3'd2, A_ISR = 3'd3,
                         A_IER = 3'd4, A_PND = 3'd5, A_CFG = 3'd6;

  // bus domain state
  logic [1:0]    ctl_hold;
  logic [CW-1:0] ld_hold, cn_hold;
  logic [2:0]    b_req, b_as1, b_as2, pend;
  logic          np_wait, cfg_post, ier_en, ovf_flag;
  logic [2:0]    b_os;
  logic [2:0]    b_ss;
  logic [CW+1:0] b_snap;

  // timer domain state
  logic [2:0]    t_rs1, t_rs2, t_rs3, t_ap;
  logic          t_st, t_ar, t_ovf, t_sreq;
  logic [1:0]    t_sa;
  logic [CW-1:0] t_cnt, t_load;
  logic [CW+1:0] t_snap;

  assign pend = b_req ^ b_as2;

  logic is_t, pend_t, launch, np_done;
  assign is_t   = (bus_addr <= A_CNT);
  assign pend_t = (bus_addr == A_CTL) ? pend[0] : (bus_addr == A_LD) ? pend[1] : pend[2];
  assign launch  = bus_we & is_t & ~pend_t & (cfg_post | ~np_wait);
  assign np_done = bus_we & is_t & np_wait & ~pend_t;
  assign bus_stall = bus_we & is_t & (pend_t | (~cfg_post & ~np_wait));

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      ctl_hold <= '0; ld_hold <= '0; cn_hold <= '0;
      b_req <= '0; b_as1 <= '0; b_as2 <= '0;
      np_wait <= 1'b0; cfg_post <= 1'b0; ier_en <= 1'b0; ovf_flag <= 1'b0;
      b_os <= '0; b_ss <= '0; b_snap <= '0;
    end else begin
      b_as1 <= t_rs3;
      b_as2 <= b_as1;
      b_os  <= {b_os[1:0], t_ovf};
      b_ss  <= {b_ss[1:0], t_sreq};
      if (b_ss[2] ^ b_ss[1]) b_snap <= t_snap;
      if (launch) begin
        case (bus_addr)
          A_CTL:   begin ctl_hold <= bus_wdata[1:0]; b_req[0] <= ~b_req[0]; end
          A_LD:    begin ld_hold  <= bus_wdata;      b_req[1] <= ~b_req[1]; end
          default: begin cn_hold  <= bus_wdata;      b_req[2] <= ~b_req[2]; end
        endcase
        if (!cfg_post) np_wait <= 1'b1;
      end else if (np_done) begin
        np_wait <= 1'b0;
      end
      if (bus_we && bus_addr == A_IER) ier_en   <= bus_wdata[0];
      if (bus_we && bus_addr == A_CFG) cfg_post <= bus_wdata[0];
      if (b_os[2] ^ b_os[1])                          ovf_flag <= 1'b1;
      else if (bus_we && bus_addr == A_ISR && bus_wdata[0]) ovf_flag <= 1'b0;
    end
  end

  assign irq = ovf_flag & ier_en;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTL:   bus_rdata = {{(CW-2){1'b0}}, b_snap[CW+1:CW]};
      A_LD:    bus_rdata = ld_hold;
      A_CNT:   bus_rdata = b_snap[CW-1:0];
      A_ISR:   bus_rdata = {{(CW-1){1'b0}}, ovf_flag};
      A_IER:   bus_rdata = {{(CW-1){1'b0}}, ier_en};
      A_PND:   bus_rdata = {{(CW-3){1'b0}}, pend};
      A_CFG:   bus_rdata = {{(CW-1){1'b0}}, cfg_post};
      default: bus_rdata = '0;
    endcase
  end

  assign t_ap = t_rs2 ^ t_rs3;

  logic t_wrap;
  assign t_wrap = t_st & (t_cnt == MAXV) & ~t_ap[2];

  always_ff @(posedge tclk or negedge trst_n) begin
    if (!trst_n) begin
      t_rs1 <= '0; t_rs2 <= '0; t_rs3 <= '0;
      t_st <= 1'b0; t_ar <= 1'b0; t_ovf <= 1'b0;
      t_cnt <= '0; t_load <= '0;
      t_sreq <= 1'b0; t_sa <= '0; t_snap <= '0;
    end else begin
      t_rs1 <= b_req;
      t_rs2 <= t_rs1;
      t_rs3 <= t_rs2;
      t_sa  <= {t_sa[0], b_ss[2]};
      if (t_ap[0])              {t_ar, t_st} <= ctl_hold;
      else if (t_wrap && !t_ar) t_st <= 1'b0;
      if (t_ap[1]) t_load <= ld_hold;
      if (t_ap[2])     t_cnt <= cn_hold;
      else if (t_wrap) t_cnt <= t_ar ? t_load : '0;
      else if (t_st)   t_cnt <= t_cnt + 1'b1;
      if (t_wrap) t_ovf <= ~t_ovf;
      if (t_sa[1] == t_sreq) begin
        t_snap <= {t_ar, t_st, t_cnt};
        t_sreq <= ~t_sreq;
      end
    end
  end

  // R7
  pend_rise_chk: assert property (@(posedge bclk) disable iff (!brst_n)
    $rose(pend[1]) |-> $past(bus_we && bus_addr == A_LD));
  // R8
  held_data_chk: assert property (@(posedge bclk) disable iff (!brst_n)
    (pend[1] && $past(pend[1])) |-> $stable(ld_hold));
  // R4
  flag_clear_chk: assert property (@(posedge bclk) disable iff (!brst_n)
    $fell(ovf_flag) |-> $past(bus_we && bus_addr == A_ISR && bus_wdata[0]));
  // R2
  oneshot_stop_chk: assert property (@(posedge tclk) disable iff (!trst_n)
    (t_st && !t_ar && t_cnt == MAXV && !t_ap[2] && !t_ap[0]) |=> !t_st);
  // R6
  count_step_chk: assert property (@(posedge tclk) disable iff (!trst_n)
    (t_st && !t_ap[2] && t_cnt != MAXV) |=> t_cnt == $past(t_cnt) + 1'b1);
  // R3
  reload_chk: assert property (@(posedge tclk) disable iff (!trst_n)
    (t_st && t_ar && t_cnt == MAXV && !t_ap[2] && !t_ap[1]) |=> t_cnt == $past(t_load));
endmodule

// File: tb/ptimer_tb.sv
`timescale 1ns/1ps
module ptimer_tb;
  localparam int CW = 32;
  localparam real TP = 37.0;
  localparam logic [CW-1:0] MAXV = '1;

  logic bclk = 0, tclk = 0, brst_n = 0, trst_n = 0;
  logic bus_we = 0;
  logic [2:0] bus_addr = 0;
  logic [CW-1:0] bus_wdata = 0, bus_rdata;
  logic bus_stall, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 bclk = ~bclk;
  always #18.5 tclk = ~tclk;

  ptimer #(.CW(CW)) u_dut (.bclk(bclk), .brst_n(brst_n), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_stall(bus_stall), .irq(irq), .tclk(tclk), .trst_n(trst_n));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [CW-1:0] d, output int stalls);
    logic s;
    stalls = 0;
    @(negedge bclk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    forever begin
      #1 s = bus_stall;
      @(posedge bclk);
      if (!s) break;
      stalls++;
      @(negedge bclk);
    end
    @(negedge bclk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [CW-1:0] d);
    @(negedge bclk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge bclk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int st;
    logic [CW-1:0] v, c1, c2;
    realtime t0, t1, dt;
    repeat (4) @(posedge tclk);
    @(negedge bclk); brst_n = 1; trst_n = 1;
    repeat (3) @(posedge bclk);
    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      check("R1 reg", v, 0);
    end
    check("R1 irq", irq, 0);
    check("R1 stall", bus_stall, 0);

    // R3 / R10 periodic sweep
    wr(3'd4, 1, st);
    for (int n = 2; n <= 9; n++) begin
      wr(3'd0, 0, st);
      wr(3'd1, MAXV - CW'(n), st);
      wr(3'd2, MAXV - CW'(n), st);
      wr(3'd3, 1, st);
      wr(3'd0, 3, st);
      @(posedge irq); wr(3'd3, 1, st);
      @(posedge irq); t0 = $realtime; wr(3'd3, 1, st);
      @(posedge irq); t1 = $realtime; wr(3'd3, 1, st);
      dt = t1 - t0 - (n + 1) * TP;
      checks++;
      if (dt > 12.0 || dt < -12.0) begin
        errors++;
        $display("FAIL %s actual=%0t expected=%0t", (n == 2) ? "R10 period" : "R3 period",
                 t1 - t0, (n + 1) * TP);
      end
    end

    // R2 / R4 / R5 one-shot and interrupt masking
    wr(3'd0, 0, st);
    wr(3'd4, 0, st);
    wr(3'd3, 1, st);
    wr(3'd2, MAXV - 3, st);
    wr(3'd0, 1, st);
    #1000;
    check("R5 masked irq", irq, 0);
    rd(3'd3, v); check("R4 flag set", v, 1);
    rd(3'd2, v); check("R2 count after wrap", v, 0);
    rd(3'd0, v); check("R2 run cleared", v, 0);
    #500;
    rd(3'd2, v); check("R2 stays stopped", v, 0);
    wr(3'd3, 0, st);
    rd(3'd3, v); check("R4 write 0 ignored", v, 1);
    wr(3'd4, 1, st);
    rd(3'd3, v);
    check("R5 irq enabled", irq, 1);
    wr(3'd3, 1, st);
    rd(3'd3, v); check("R4 cleared", v, 0);
    check("R5 irq low", irq, 0);
    wr(3'd4, 0, st);

    // R6 continuous count
    wr(3'd1, 0, st);
    wr(3'd2, 0, st);
    wr(3'd0, 3, st);
    #300;
    rd(3'd2, c1);
    #2000;
    rd(3'd2, c2);
    checks++;
    if (c2 - c1 < 46 || c2 - c1 > 62) begin
      errors++;
      $display("FAIL R6 delta actual=%0d expected=54", c2 - c1);
    end
    wr(3'd0, 0, st);

    // R7 / R8 posted writes
    wr(3'd6, 1, st);
    wr(3'd1, 32'h1234, st);
    check("R7 posted no stall", st, 0);
    rd(3'd5, v); check("R7 pending load", v, 3'b010);
    wr(3'd1, 32'h5678, st);
    check("R8 held write stalls", st > 0, 1);
    #600;
    rd(3'd5, v); check("R7 pending cleared", v, 0);
    rd(3'd1, v); check("R8 second value", v, 32'h5678);

    // R9 non-posted writes
    wr(3'd6, 0, st);
    wr(3'd2, 7, st);
    check("R9 stalls", st >= 3, 1);
    rd(3'd5, v); check("R9 pending clear", v, 0);
    #600;
    rd(3'd2, v); check("R9 count landed", v, 7);

    done = 1;
    summary();
  end
endmodule